// File: doc/BRIEF.md
# Coprocessor Branch and Program-Counter Unit

This unit keeps the program counter of a small low-power coprocessor. The coprocessor fetches 32-bit instructions from a memory that is addressed in 32-bit words. For each instruction the unit computes the address of the next one. It looks at the instruction word, the four 16-bit general registers and a pair of condition flags. The flags are saved from the most recent ALU result; the branch never does a compare of its own for the flags. It also reports whether a jump was taken.

There are two kinds of jump:
- **Absolute jump.** The target comes either from an 11-bit immediate word address or from the low bits of a selected register. The jump is taken always, on the saved zero flag, or on the saved overflow flag.
- **Relative jump.** The target is a signed word offset added to the current counter. The jump is taken after comparing R0 with a 16-bit threshold carried in the instruction.

Any other instruction, and any jump that is not taken, moves the counter forward by one word.

The counter changes only on a cycle where the instruction strobe is high. In each such cycle the unit picks one of three update actions: HOLD keeps the counter (no instruction), STEP adds one word, and JUMP loads the target.

The transitions are as follows:
- SEQ→STEP for a non-jump instruction.
- ABS/REL→JUMP when the condition holds.
- ABS/REL→STEP when it fails.

Top module: `cop_branch_unit`

## Requirements
- R1: A synchronous active-high `rst` sets `pc` to 0, drives `jump_taken` low, and clears both saved flags, so a zero- or overflow-conditioned jump right after reset is not taken.
- R2: An instruction is a jump only if bits [31:28] equal 8. Bits [27:25] then select the kind: 0 is absolute and 1 is relative. Every other instruction, including opcode 8 with any other variant value, advances `pc` by one and leaves `jump_taken` low.
- R3: For an absolute jump with bit 21 clear and type 0 in bits [24:22], `pc` becomes the 11-bit immediate in bits [12:2] and `jump_taken` is high.
- R4: For an absolute jump with bit 21 set, the target is the low 11 bits of the register numbered by bits [1:0] (0 to 3). The upper 5 bits of that register are ignored.
- R5: Absolute type 1 jumps only when the saved zero flag is set.
- R6: Absolute type 2 jumps only when the saved overflow flag is set.
- R7: Absolute types 3 to 7 are never taken, whatever the flags are.
- R8: The saved flags load `alu_zero` and `alu_ovf` only in a cycle where `alu_done` is high, and hold otherwise. A jump issued in the same cycle as an ALU strobe uses the flag values from before that strobe.
- R9: A relative jump, when taken, adds the signed 8-bit step in bits [24:17] to `pc`.
- R10: A relative jump compares the unsigned R0 with the unsigned threshold in bits [15:0]. If bit 16 is set it jumps when R0 ≥ threshold; if bit 16 is clear it jumps when R0 < threshold.
- R11: While `instr_valid` is low, `pc` holds. `jump_taken` is high only in the cycle right after a taken jump.
- R12: All counter arithmetic wraps modulo 2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | The instruction word is executed in this cycle |
| instr | input | 32 | Current instruction word |
| reg0 | input | 16 | General register R0 (also the relative-jump comparand) |
| reg1 | input | 16 | General register R1 |
| reg2 | input | 16 | General register R2 |
| reg3 | input | 16 | General register R3 |
| alu_done | input | 1 | ALU result strobe; loads the saved flags |
| alu_zero | input | 1 | Zero flag of the ALU result |
| alu_ovf | input | 1 | Overflow flag of the ALU result |
| pc | output | 11 | Program counter, in words |
| jump_taken | output | 1 | The last executed instruction was a taken jump |

## Verification
A corrupted saved flag cannot be seen until the next zero- or overflow-conditioned jump. That jump then lands on the wrong address, so the bench follows each flag change with conditioned jumps, both right away and after unrelated instructions. A wrong counter value shows on `pc` one cycle after the instruction that produced it. Every later STEP carries the error forward, so tracking the expected counter across a scenario exposes both a bad target and a missing wrap. Relative jumps are probed exactly at the threshold and with R0 at its maximum, so a signed compare or an off-by-one compare shows up as a one-word or jump-sized error.

// File: rtl/bru_pkg.sv
package bru_pkg;
    localparam int INSTR_W = 32;
    localparam int PC_W    = 11;
    localparam int DATA_W  = 16;
    localparam int NREG    = 4;
    localparam int RIDX_W  = $clog2(NREG);
    localparam int STEP_W  = 8;

    localparam logic [3:0] OPC_JUMP  = 4'd8;
    localparam logic [2:0] VAR_ABS   = 3'd0;
    localparam logic [2:0] VAR_REL   = 3'd1;

    typedef enum logic [1:0] {
        CLS_SEQ,
        CLS_ABS,
        CLS_REL
    } ins_class_e;

    typedef enum logic [2:0] {
        COND_ALWAYS,
        COND_ZERO,
        COND_OVF,
        COND_NEVER,
        COND_GE,
        COND_LT
    } cond_e;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_STEP,
        OP_JUMP
    } pc_op_e;

    typedef struct packed {
        ins_class_e               cls;
        cond_e                    cond;
        logic                     sel_reg;
        logic [RIDX_W-1:0]        reg_idx;
        logic [PC_W-1:0]          imm;
        logic [STEP_W-1:0]        step;
        logic [DATA_W-1:0]        thr;
    } decoded_t;
endpackage

// File: rtl/bru_decode.sv
module bru_decode
    import bru_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output decoded_t           dec
);
    logic [3:0] opcode;
    logic [2:0] variant;
    logic [2:0] kind;

    assign opcode  = instr[31:28];
    assign variant = instr[27:25];
    assign kind    = instr[24:22];

    always_comb begin
        dec.sel_reg = instr[21];
        dec.reg_idx = instr[RIDX_W-1:0];
        dec.imm     = instr[2 +: PC_W];
        dec.step    = instr[17 +: STEP_W];
        dec.thr     = instr[DATA_W-1:0];
        dec.cls     = CLS_SEQ;
        dec.cond    = COND_NEVER;
        if (opcode == OPC_JUMP) begin
            unique case (variant)
                VAR_ABS: begin
                    dec.cls = CLS_ABS;
                    unique case (kind)
                        3'd0:    dec.cond = COND_ALWAYS;
                        3'd1:    dec.cond = COND_ZERO;
                        3'd2:    dec.cond = COND_OVF;
                        default: dec.cond = COND_NEVER;
                    endcase
                end
                VAR_REL: begin
                    dec.cls  = CLS_REL;
                    dec.cond = instr[16] ? COND_GE : COND_LT;
                end
                default: begin
                    dec.cls  = CLS_SEQ;
                    dec.cond = COND_NEVER;
                end
            endcase
        end
    end
endmodule

// File: rtl/bru_cond.sv
module bru_cond
    import bru_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alu_done,
    input  logic          alu_zero,
    input  logic          alu_ovf,
    input  cond_e         cond,
    input  logic [DW-1:0] r0,
    input  logic [DW-1:0] thr,
    output logic          met
);
    logic zero_q;
    logic ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else if (alu_done) begin
            zero_q <= alu_zero;
            ovf_q  <= alu_ovf;
        end
    end

    always_comb begin
        unique case (cond)
            COND_ALWAYS: met = 1'b1;
            COND_ZERO:   met = zero_q;
            COND_OVF:    met = ovf_q;
            COND_GE:     met = (r0 >= thr);
            COND_LT:     met = (r0 < thr);
            default:     met = 1'b0;
        endcase
    end

    // R8: flags change only under an ALU strobe
    a_r8_flags_hold: assert property (@(posedge clk) disable iff (rst)
        !alu_done |=> ($stable(zero_q) && $stable(ovf_q)));

    // R8: a strobe loads the presented flags
    a_r8_flags_load: assert property (@(posedge clk) disable iff (rst)
        alu_done |=> (zero_q == $past(alu_zero) && ovf_q == $past(alu_ovf)));
endmodule

// File: rtl/bru_target.sv
module bru_target
    import bru_pkg::*;
#(
    parameter int PW = PC_W,
    parameter int DW = DATA_W,
    parameter int NR = NREG,
    parameter int SW = STEP_W
) (
    input  logic [PW-1:0]          pc,
    input  logic                   sel_reg,
    input  logic [$clog2(NR)-1:0]  reg_idx,
    input  logic [PW-1:0]          imm,
    input  logic [SW-1:0]          step,
    input  logic [NR-1:0][DW-1:0]  regs,
    output logic [PW-1:0]          tgt_abs,
    output logic [PW-1:0]          tgt_rel,
    output logic [PW-1:0]          tgt_seq
);
    localparam int EXT_W = PW - SW;

    logic [NR-1:0][PW-1:0] reg_lo;
    logic [NR-1:0]         unused_hi;

    for (genvar i = 0; i < NR; i++) begin : g_regs
        assign reg_lo[i]    = regs[i][PW-1:0];
        assign unused_hi[i] = ^regs[i][DW-1:PW];
    end

    assign tgt_abs = sel_reg ? reg_lo[reg_idx] : imm;
    assign tgt_rel = pc + {{EXT_W{step[SW-1]}}, step};
    assign tgt_seq = pc + PW'(1);
endmodule

// File: rtl/cop_branch_unit.sv
module cop_branch_unit
    import bru_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                instr_valid,
    input  logic [INSTR_W-1:0]  instr,
    input  logic [DATA_W-1:0]   reg0,
    input  logic [DATA_W-1:0]   reg1,
    input  logic [DATA_W-1:0]   reg2,
    input  logic [DATA_W-1:0]   reg3,
    input  logic                alu_done,
    input  logic                alu_zero,
    input  logic                alu_ovf,
    output logic [PC_W-1:0]     pc,
    output logic                jump_taken
);
    decoded_t                dec;
    logic                    met;
    logic [NREG-1:0][DATA_W-1:0] regs;
    logic [PC_W-1:0]         tgt_abs;
    logic [PC_W-1:0]         tgt_rel;
    logic [PC_W-1:0]         tgt_seq;
    logic [PC_W-1:0]         pc_q;
    logic [PC_W-1:0]         pc_nxt;
    logic                    taken_q;
    pc_op_e                  op;

    assign regs = {reg3, reg2, reg1, reg0};

    bru_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    bru_cond #(.DW(DATA_W)) u_cond (
        .clk      (clk),
        .rst      (rst),
        .alu_done (alu_done),
        .alu_zero (alu_zero),
        .alu_ovf  (alu_ovf),
        .cond     (dec.cond),
        .r0       (reg0),
        .thr      (dec.thr),
        .met      (met)
    );

    bru_target #(.PW(PC_W), .DW(DATA_W), .NR(NREG), .SW(STEP_W)) u_tgt (
        .pc      (pc_q),
        .sel_reg (dec.sel_reg),
        .reg_idx (dec.reg_idx),
        .imm     (dec.imm),
        .step    (dec.step),
        .regs    (regs),
        .tgt_abs (tgt_abs),
        .tgt_rel (tgt_rel),
        .tgt_seq (tgt_seq)
    );

    // choose the update action
    always_comb begin
        if (!instr_valid) begin
            op = OP_HOLD;
        end else begin
            unique case (dec.cls)
                CLS_ABS, CLS_REL: op = met ? OP_JUMP : OP_STEP;
                default:          op = OP_STEP;
            endcase
        end
    end

    always_comb begin
        unique case (op)
            OP_HOLD: pc_nxt = pc_q;
            OP_JUMP: pc_nxt = (dec.cls == CLS_ABS) ? tgt_abs : tgt_rel;
            default: pc_nxt = tgt_seq;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            taken_q <= 1'b0;
        end else begin
            pc_q    <= pc_nxt;
            taken_q <= (op == OP_JUMP);
        end
    end

    assign pc         = pc_q;
    assign jump_taken = taken_q;

    // R1: reset clears counter and taken indication
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (pc_q == '0 && !taken_q));

    // R11: no instruction, no counter movement
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> ($stable(pc_q) && !taken_q));

    // R2: non-jump instruction steps by one word
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && dec.cls == CLS_SEQ) |=> (pc_q == $past(pc_q) + PC_W'(1) && !taken_q));

    // R7: reserved absolute types never jump
    a_r7_never: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && dec.cls == CLS_ABS && instr[24:22] > 3'd2) |=> !taken_q);

    // R3: unconditional immediate jump loads the immediate
    a_r3_imm_jump: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && dec.cls == CLS_ABS && instr[24:22] == 3'd0 && !instr[21])
        |=> (taken_q && pc_q == $past(instr[12:2])));
endmodule

// File: tb/cop_branch_unit_test.sv
`timescale 1ns/1ps
module cop_branch_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [15:0] reg0 = '0, reg1 = '0, reg2 = '0, reg3 = '0;
    logic        alu_done = 1'b0, alu_zero = 1'b0, alu_ovf = 1'b0;
    logic [10:0] pc;
    logic        jump_taken;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [10:0] exp_pc = '0;

    always #4 clk = ~clk;

    cop_branch_unit uut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .reg0(reg0), .reg1(reg1), .reg2(reg2), .reg3(reg3),
        .alu_done(alu_done), .alu_zero(alu_zero), .alu_ovf(alu_ovf),
        .pc(pc), .jump_taken(jump_taken)
    );

    function automatic logic [31:0] mk_abs(input logic [2:0] typ, input logic sel,
                                           input logic [10:0] imm, input logic [1:0] rd);
        return {4'd8, 3'd0, typ, sel, 8'd0, imm, rd};
    endfunction

    function automatic logic [31:0] mk_rel(input logic [7:0] step, input logic ge,
                                           input logic [15:0] thr);
        return {4'd8, 3'd1, step, ge, thr};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic exec(input logic [31:0] ins);
        @(negedge clk);
        instr = ins;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        instr = '0;
    endtask

    task automatic run(input logic [31:0] ins, input bit exp_t,
                       input logic [10:0] tgt, input string req);
        exec(ins);
        exp_pc = exp_t ? tgt : exp_pc + 11'd1;
        chk(req, {21'd0, pc}, {21'd0, exp_pc});
        chk(req, {31'd0, jump_taken}, {31'd0, exp_t});
    endtask

    task automatic alu(input logic z, input logic o);
        @(negedge clk);
        alu_done = 1'b1; alu_zero = z; alu_ovf = o;
        @(negedge clk);
        alu_done = 1'b0; alu_zero = 1'b0; alu_ovf = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 pc", {21'd0, pc}, 32'd0);
        chk("R1 taken", {31'd0, jump_taken}, 32'd0);
        rst = 1'b0;
        exp_pc = '0;
        run(mk_abs(3'd1, 1'b0, 11'd100, 2'd0), 1'b0, 11'd0, "R1 zero flag cleared");
        run(mk_abs(3'd2, 1'b0, 11'd100, 2'd0), 1'b0, 11'd0, "R1 ovf flag cleared");
    endtask

    task automatic t_seq;
        run(32'h1234_5678, 1'b0, 11'd0, "R2 non-jump");
        run({4'd8, 3'd2, 25'h1FF_FFFF}, 1'b0, 11'd0, "R2 opcode 8 variant 2");
        run({4'd7, 3'd0, 3'd0, 1'b0, 8'd0, 11'd300, 2'd0}, 1'b0, 11'd0, "R2 opcode 7");
    endtask

    task automatic t_abs_imm;
        run(mk_abs(3'd0, 1'b0, 11'h2AB, 2'd3), 1'b1, 11'h2AB, "R3 immediate jump");
        run(mk_abs(3'd0, 1'b0, 11'd5, 2'd0), 1'b1, 11'd5, "R3 immediate jump low");
    endtask

    task automatic t_reg;
        reg2 = 16'hF9C5;
        reg3 = 16'h0123;
        run(mk_abs(3'd0, 1'b1, 11'd7, 2'd2), 1'b1, 11'h1C5, "R4 reg2 upper bits ignored");
        run(mk_abs(3'd0, 1'b1, 11'd7, 2'd3), 1'b1, 11'h123, "R4 reg3");
    endtask

    task automatic t_flags;
        alu(1'b1, 1'b0);
        run(mk_abs(3'd1, 1'b0, 11'd50, 2'd0), 1'b1, 11'd50, "R5 zero set");
        run(mk_abs(3'd2, 1'b0, 11'd60, 2'd0), 1'b0, 11'd0, "R6 ovf clear");
        alu(1'b0, 1'b1);
        run(mk_abs(3'd1, 1'b0, 11'd70, 2'd0), 1'b0, 11'd0, "R5 zero clear");
        run(mk_abs(3'd2, 1'b0, 11'd80, 2'd0), 1'b1, 11'd80, "R6 ovf set");
    endtask

    task automatic t_never;
        alu(1'b1, 1'b1);
        for (int t = 3; t < 8; t++)
            run(mk_abs(3'(t), 1'b0, 11'd400, 2'd0), 1'b0, 11'd0, "R7 reserved type");
    endtask

    task automatic t_hold_flags;
        alu(1'b1, 1'b0);
        run(32'h0000_0001, 1'b0, 11'd0, "R8 filler");
        run(mk_abs(3'd0, 1'b0, 11'd90, 2'd0), 1'b1, 11'd90, "R8 filler jump");
        run(mk_abs(3'd1, 1'b0, 11'd120, 2'd0), 1'b1, 11'd120, "R8 zero held");
        // strobe and jump in the same cycle: old flag (1) applies
        @(negedge clk);
        instr = mk_abs(3'd1, 1'b0, 11'd140, 2'd0);
        instr_valid = 1'b1;
        alu_done = 1'b1; alu_zero = 1'b0; alu_ovf = 1'b0;
        @(negedge clk);
        instr_valid = 1'b0; alu_done = 1'b0; instr = '0;
        exp_pc = 11'd140;
        chk("R8 same-cycle old flag pc", {21'd0, pc}, {21'd0, exp_pc});
        chk("R8 same-cycle old flag taken", {31'd0, jump_taken}, 32'd1);
        run(mk_abs(3'd1, 1'b0, 11'd160, 2'd0), 1'b0, 11'd0, "R8 new flag loaded");
    endtask

    task automatic t_rel;
        run(mk_abs(3'd0, 1'b0, 11'd100, 2'd0), 1'b1, 11'd100, "R9 setup");
        reg0 = 16'd10;
        run(mk_rel(8'hFD, 1'b1, 16'd10), 1'b1, 11'd97, "R9 R10 back step ge equal");
        reg0 = 16'd9;
        run(mk_rel(8'hFD, 1'b1, 16'd10), 1'b0, 11'd0, "R10 ge fails");
        run(mk_rel(8'd5, 1'b0, 16'd10), 1'b1, 11'd103, "R9 R10 forward lt");
        reg0 = 16'hFFFF;
        run(mk_rel(8'd5, 1'b0, 16'd10), 1'b0, 11'd0, "R10 unsigned compare");
        reg0 = 16'd10;
        run(mk_rel(8'd5, 1'b0, 16'd10), 1'b0, 11'd0, "R10 lt at equal");
    endtask

    task automatic t_wrap;
        run(mk_abs(3'd0, 1'b0, 11'h7FF, 2'd0), 1'b1, 11'h7FF, "R12 setup");
        run(32'h0, 1'b0, 11'd0, "R12 step wraps to 0");
        run(mk_abs(3'd0, 1'b0, 11'd2, 2'd0), 1'b1, 11'd2, "R12 setup rel");
        reg0 = 16'd0;
        run(mk_rel(8'hFB, 1'b0, 16'd10), 1'b1, 11'd2045, "R12 rel wraps below 0");
        run(mk_rel(8'd4, 1'b1, 16'd0), 1'b1, 11'd1, "R12 rel wraps above max");
    endtask

    task automatic t_idle;
        run(mk_abs(3'd0, 1'b0, 11'd33, 2'd0), 1'b1, 11'd33, "R11 setup");
        instr = mk_abs(3'd0, 1'b0, 11'd999, 2'd0);
        repeat (3) @(negedge clk);
        chk("R11 pc held", {21'd0, pc}, 32'd33);
        chk("R11 taken low", {31'd0, jump_taken}, 32'd0);
        instr = '0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_seq();
        t_abs_imm();
        t_reg();
        t_flags();
        t_never();
        t_hold_flags();
        t_rel();
        t_wrap();
        t_idle();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule